// File: doc/BRIEF.md
# UART Receive Queue with Fill-Level Trigger

This block is the receive-side character store of one UART channel. The serial receiver pushes each completed character, together with three error status bits that belong to that character, and the host register interface pops entries in arrival order. The block keeps a fill level and raises a trigger request once enough characters are waiting, so that the host is interrupted in batches and not for every character.

The trigger threshold has two sources. A four-bit programmable threshold, counted in steps of four characters, takes precedence whenever it is nonzero. When it is zero, a two-bit selector picks one of four fixed levels. With the queue disabled, the store behaves as a single holding register and the threshold is one character. A flush input empties the queue in a single cycle.

Top module: `uart_rxq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `level` is 0, `trig_req` is 0, `overrun` is 0, and `rd_data` and `rd_err` are 0.
- R2: Entries leave in the order they were accepted, each read returning the 8-bit character with the 3-bit error field written with it; `rd_data`/`rd_err` update on the clock edge that samples `rd_en` and hold until the next read.
- R3: A read while `level` is 0 returns `rd_data` = 0 and `rd_err` = 0 and leaves `level` unchanged.
- R4: With `fifo_en` = 1 and `level` = 64, a write without a read is dropped: `level` stays 64, `overrun` is 1 for the one cycle after, and the dropped character never appears at the read port.
- R5: A simultaneous read and write at `level` = 64 are both accepted and `level` stays 64.
- R6: With `fifo_en` = 0 the capacity is one entry; a write while one entry is held is dropped and raises `overrun`.
- R7: When `prog_trig` is nonzero and `fifo_en` = 1, the threshold is 4 × `prog_trig` (4 to 60).
- R8: When `prog_trig` is 0 and `fifo_en` = 1, `lvl_sel` picks the threshold: 0 gives 8, 1 gives 16, 2 gives 56, 3 gives 60.
- R9: When `fifo_en` = 0, the threshold is 1 regardless of `prog_trig` and `lvl_sel`.
- R10: `trig_req` is 1 exactly while `level` is at or above the threshold, changing on the same edge as `level`, and drops when `level` falls below it.
- R11: `flush` sets `level` to 0 and `trig_req` to 0 on the next edge, ignores a read or write in the same cycle, and the next accepted write is the next entry read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue enable; 0 selects single-entry holding mode |
| flush | input | 1 | Empty the queue on this edge |
| lvl_sel | input | 2 | Fixed threshold selector |
| prog_trig | input | 4 | Programmable threshold in steps of four; 0 defers to `lvl_sel` |
| wr_en | input | 1 | Push a character from the receiver |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error status bits of the character |
| rd_en | input | 1 | Pop a character for the host |
| rd_data | output | 8 | Character of the last read, 0 after an empty read |
| rd_err | output | 3 | Error bits of the last read, 0 after an empty read |
| level | output | 7 | Number of stored entries, 0 to 64 |
| trig_req | output | 1 | Fill level at or above the active threshold |
| overrun | output | 1 | One-cycle pulse after a dropped write |

## Verification
The ordering function is driven by a vector table that interleaves pushes, pops, simultaneous push-and-pop at low fill and pops of an empty queue, which separates correct pointer advance from off-by-one or stale-data reads and shows that error bits travel with their own character. The threshold logic is probed by filling from empty under each selector code, two programmable values and the disabled mode, recording the first level at which the request rises; this tells apart the precedence of the two sources and the encoding of each. A full-queue run with an extra push, a push-and-pop at full and a complete drain checks that the dropped character never surfaces and that the request falls at the right level, and separate runs cover single-entry mode and flush with a concurrent write.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  localparam int ENTRY_W = $bits(rxq_entry_t);
endpackage

// File: rtl/uart_rxq_mem.sv
module uart_rxq_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] ram [DEPTH];

  // single clocked process, read-first, so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          flush,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          overrun,
  output logic          rd_hit
);
  logic full, empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // disabled mode behaves as a one-entry holding register
  assign full  = fifo_en ? (count == CW'(DEPTH)) : (count != '0);
  assign empty = (count == '0);

  assign rd_go = rd_en && !empty && !flush;
  assign wr_go = wr_en && !flush && (!full || rd_go);

  assign count_nxt = flush ? '0 : (count + CW'(wr_go) - CW'(rd_go));

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
      rd_hit  <= 1'b0;
    end else begin
      count   <= count_nxt;
      overrun <= wr_en && !flush && !wr_go;
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (wr_go) wptr <= bump(wptr);
        if (rd_go) rptr <= bump(rptr);
      end
      if (rd_en && !flush) rd_hit <= rd_go;
    end
  end
endmodule

// File: rtl/uart_rxq_trig.sv
module uart_rxq_trig #(
  parameter int DEPTH     = 64,
  parameter int TRIG_STEP = 4,
  parameter int SEL_LVL0  = 8,
  parameter int SEL_LVL1  = 16,
  parameter int SEL_LVL2  = 56,
  parameter int SEL_LVL3  = 60,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [1:0]    lvl_sel,
  input  logic [3:0]    prog_trig,
  input  logic [CW-1:0] count_nxt,
  output logic          trig_req
);
  logic [CW-1:0] thr;

  always_comb begin
    if (!fifo_en) begin
      thr = CW'(1);
    end else if (prog_trig != 4'd0) begin
      thr = CW'(int'(prog_trig) * TRIG_STEP);
    end else begin
      unique case (lvl_sel)
        2'd0:    thr = CW'(SEL_LVL0);
        2'd1:    thr = CW'(SEL_LVL1);
        2'd2:    thr = CW'(SEL_LVL2);
        default: thr = CW'(SEL_LVL3);
      endcase
    end
  end

  // compared against the next count so the request moves with level
  always_ff @(posedge clk) begin
    if (rst) trig_req <= 1'b0;
    else     trig_req <= (count_nxt >= thr);
  end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int TRIG_STEP = 4,
  parameter int SEL_LVL0  = 8,
  parameter int SEL_LVL1  = 16,
  parameter int SEL_LVL2  = 56,
  parameter int SEL_LVL3  = 60,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              flush,
  input  logic [1:0]        lvl_sel,
  input  logic [3:0]        prog_trig,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  wr_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W-1:0]  rd_err,
  output logic [CW-1:0]     level,
  output logic              trig_req,
  output logic              overrun
);
  logic          wr_go, rd_go, rd_hit;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count_nxt;
  rxq_entry_t    wr_ent, rd_ent;

  assign wr_ent = '{err: wr_err, data: wr_data};

  uart_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .flush(flush),
    .wr_en(wr_en), .rd_en(rd_en), .wr_go(wr_go), .rd_go(rd_go),
    .wptr(wptr), .rptr(rptr), .count(level), .count_nxt(count_nxt),
    .overrun(overrun), .rd_hit(rd_hit)
  );

  uart_rxq_mem #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_mem (
    .clk(clk), .we(wr_go), .waddr(wptr), .wdata(wr_ent),
    .re(rd_go), .raddr(rptr), .rdata(rd_ent)
  );

  uart_rxq_trig #(
    .DEPTH(DEPTH), .TRIG_STEP(TRIG_STEP),
    .SEL_LVL0(SEL_LVL0), .SEL_LVL1(SEL_LVL1),
    .SEL_LVL2(SEL_LVL2), .SEL_LVL3(SEL_LVL3)
  ) u_trig (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .lvl_sel(lvl_sel),
    .prog_trig(prog_trig), .count_nxt(count_nxt), .trig_req(trig_req)
  );

  assign rd_data = rd_hit ? rd_ent.data : '0;
  assign rd_err  = rd_hit ? rd_ent.err  : '0;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH     = 64,
  parameter int TRIG_STEP = 4,
  parameter int SEL_LVL0  = 8,
  parameter int SEL_LVL1  = 16,
  parameter int SEL_LVL2  = 56,
  parameter int SEL_LVL3  = 60,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          flush,
  input logic [1:0]    lvl_sel,
  input logic [3:0]    prog_trig,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    rd_data,
  input logic [2:0]    rd_err,
  input logic [CW-1:0] level,
  input logic          trig_req,
  input logic          overrun
);
  int expect_thr;
  always_comb begin
    if (!fifo_en)               expect_thr = 1;
    else if (prog_trig != 4'd0) expect_thr = int'(prog_trig) * TRIG_STEP;
    else if (lvl_sel == 2'd0)   expect_thr = SEL_LVL0;
    else if (lvl_sel == 2'd1)   expect_thr = SEL_LVL1;
    else if (lvl_sel == 2'd2)   expect_thr = SEL_LVL2;
    else                        expect_thr = SEL_LVL3;
  end

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH);

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (level == $past(level) || level == $past(level) + 1 ||
                level + 1 == $past(level)));

  // R3
  empty_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && level == '0 && !flush) |=> (rd_data == '0 && rd_err == '0 && level == '0));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && wr_en && !rd_en && !flush && int'(level) == DEPTH)
      |=> (overrun && int'(level) == DEPTH));

  // R6
  hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && wr_en && !rd_en && !flush && level != '0) |=> overrun);

  // R10
  trig_level_chk: assert property (@(posedge clk) disable iff (rst)
    trig_req == (int'(level) >= $past(expect_thr)));

  // R11
  flush_clr_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0 && !trig_req));
endmodule

bind uart_rxq uart_rxq_chk #(
  .DEPTH(DEPTH), .TRIG_STEP(TRIG_STEP),
  .SEL_LVL0(SEL_LVL0), .SEL_LVL1(SEL_LVL1),
  .SEL_LVL2(SEL_LVL2), .SEL_LVL3(SEL_LVL3)
) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .flush(flush),
  .lvl_sel(lvl_sel), .prog_trig(prog_trig), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .rd_err(rd_err), .level(level),
  .trig_req(trig_req), .overrun(overrun)
);

// File: tb/tb_uart_rxq.sv
module tb_uart_rxq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0, flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] lvl_sel = 2'd0;
  logic [3:0] prog_trig = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] wr_err = 3'd0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [6:0] level;
  logic       trig_req, overrun;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_rxq dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .flush(flush),
    .lvl_sel(lvl_sel), .prog_trig(prog_trig), .wr_en(wr_en),
    .wr_data(wr_data), .wr_err(wr_err), .rd_en(rd_en),
    .rd_data(rd_data), .rd_err(rd_err), .level(level),
    .trig_req(trig_req), .overrun(overrun)
  );

  // {wr, rd, data[8], err[3], exp_level[7], exp_rdata[8], exp_rerr[3], exp_trig}
  // configuration: enabled, programmable threshold 1 -> 4 characters
  localparam logic [31:0] VEC [16] = '{
    {1'b1, 1'b0, 8'hA1, 3'd1, 7'd1, 8'h00, 3'd0, 1'b0},
    {1'b1, 1'b0, 8'hB2, 3'd2, 7'd2, 8'h00, 3'd0, 1'b0},
    {1'b1, 1'b0, 8'hC3, 3'd4, 7'd3, 8'h00, 3'd0, 1'b0},
    {1'b1, 1'b0, 8'hD4, 3'd7, 7'd4, 8'h00, 3'd0, 1'b1},
    {1'b0, 1'b1, 8'h00, 3'd0, 7'd3, 8'hA1, 3'd1, 1'b0},
    {1'b1, 1'b1, 8'hE5, 3'd0, 7'd3, 8'hB2, 3'd2, 1'b0},
    {1'b1, 1'b0, 8'hF6, 3'd3, 7'd4, 8'hB2, 3'd2, 1'b1},
    {1'b0, 1'b1, 8'h00, 3'd0, 7'd3, 8'hC3, 3'd4, 1'b0},
    {1'b0, 1'b1, 8'h00, 3'd0, 7'd2, 8'hD4, 3'd7, 1'b0},
    {1'b0, 1'b1, 8'h00, 3'd0, 7'd1, 8'hE5, 3'd0, 1'b0},
    {1'b0, 1'b1, 8'h00, 3'd0, 7'd0, 8'hF6, 3'd3, 1'b0},
    {1'b0, 1'b1, 8'h00, 3'd0, 7'd0, 8'h00, 3'd0, 1'b0},
    {1'b1, 1'b0, 8'h5A, 3'd5, 7'd1, 8'h00, 3'd0, 1'b0},
    {1'b1, 1'b1, 8'h77, 3'd6, 7'd1, 8'h5A, 3'd5, 1'b0},
    {1'b0, 1'b1, 8'h00, 3'd0, 7'd0, 8'h77, 3'd6, 1'b0},
    {1'b0, 1'b1, 8'h00, 3'd0, 7'd0, 8'h00, 3'd0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic op(input logic w, input logic r, input logic [7:0] d, input logic [2:0] e);
    wr_en = w; rd_en = r; wr_data = d; wr_err = e;
    cyc();
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    cyc();
    flush = 1'b0;
    cyc();
  endtask

  task automatic measure_thr(input logic en, input logic [1:0] sel, input logic [3:0] pt,
                             input int exp, input string req);
    int hit = 0;
    fifo_en = en; lvl_sel = sel; prog_trig = pt;
    do_flush();
    for (int k = 1; k <= 64; k++) begin
      op(1'b1, 1'b0, 8'(k), 3'd0);
      if (trig_req && hit == 0) hit = int'(level);
    end
    check(req, hit, exp);
    do_flush();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc();
    // R1 reset state
    check("R1 level", int'(level), 0);
    check("R1 trig", int'(trig_req), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 rd_data", int'(rd_data), 0);
    rst = 1'b0;
    cyc();
    check("R1 level after release", int'(level), 0);

    // vector table, R2 R3 R10
    fifo_en = 1'b1; prog_trig = 4'd1; lvl_sel = 2'd0;
    cyc();
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      v = VEC[i];
      op(v[31], v[30], v[29:22], v[21:19]);
      check($sformatf("R2 vec%0d level", i), int'(level), int'(v[18:12]));
      check($sformatf("R2 vec%0d rd_data", i), int'(rd_data), int'(v[11:4]));
      check($sformatf("R3 vec%0d rd_err", i), int'(rd_err), int'(v[3:1]));
      check($sformatf("R10 vec%0d trig", i), int'(trig_req), int'(v[0]));
    end

    // R7 R8 R9 threshold sources
    measure_thr(1'b1, 2'd0, 4'd0, 8,  "R8 sel0");
    measure_thr(1'b1, 2'd1, 4'd0, 16, "R8 sel1");
    measure_thr(1'b1, 2'd2, 4'd0, 56, "R8 sel2");
    measure_thr(1'b1, 2'd3, 4'd0, 60, "R8 sel3");
    measure_thr(1'b1, 2'd2, 4'd1, 4,  "R7 prog1");
    measure_thr(1'b1, 2'd0, 4'd15, 60, "R7 prog15");
    measure_thr(1'b0, 2'd3, 4'd5, 1,  "R9 disabled");

    // R4 R5 full queue, R10 drop on drain
    fifo_en = 1'b1; lvl_sel = 2'd0; prog_trig = 4'd15;
    do_flush();
    for (int k = 1; k <= 64; k++) op(1'b1, 1'b0, 8'(k), 3'(k % 8));
    check("R4 full level", int'(level), 64);
    check("R10 trig at full", int'(trig_req), 1);
    op(1'b1, 1'b0, 8'hEE, 3'd7);
    check("R4 overrun", int'(overrun), 1);
    check("R4 level kept", int'(level), 64);
    cyc();
    check("R4 overrun pulse ends", int'(overrun), 0);
    op(1'b1, 1'b1, 8'hDD, 3'd5);
    check("R5 level at full", int'(level), 64);
    check("R5 read data", int'(rd_data), 1);
    check("R5 no overrun", int'(overrun), 0);
    for (int j = 2; j <= 64; j++) begin
      op(1'b0, 1'b1, 8'h00, 3'd0);
      check("R4 drain data", int'(rd_data), j);
      check("R2 drain err", int'(rd_err), j % 8);
      check("R10 trig on drain", int'(trig_req), int'(int'(level) >= 60));
    end
    op(1'b0, 1'b1, 8'h00, 3'd0);
    check("R5 last data", int'(rd_data), 8'hDD);
    check("R5 last err", int'(rd_err), 5);
    check("R4 empty after drain", int'(level), 0);

    // R6 single-entry mode
    fifo_en = 1'b0;
    do_flush();
    op(1'b1, 1'b0, 8'h11, 3'd1);
    check("R6 level one", int'(level), 1);
    op(1'b1, 1'b0, 8'h22, 3'd2);
    check("R6 overrun", int'(overrun), 1);
    check("R6 level held", int'(level), 1);
    op(1'b0, 1'b1, 8'h00, 3'd0);
    check("R6 held data", int'(rd_data), 8'h11);

    // R11 flush with concurrent write
    fifo_en = 1'b1; prog_trig = 4'd1;
    do_flush();
    for (int k = 0; k < 5; k++) op(1'b1, 1'b0, 8'(8'h40 + k), 3'd0);
    check("R11 before flush", int'(trig_req), 1);
    flush = 1'b1;
    op(1'b1, 1'b0, 8'h99, 3'd1);
    flush = 1'b0;
    check("R11 level cleared", int'(level), 0);
    check("R11 trig cleared", int'(trig_req), 0);
    op(1'b1, 1'b0, 8'h33, 3'd3);
    op(1'b0, 1'b1, 8'h00, 3'd0);
    check("R11 next data", int'(rd_data), 8'h33);
    check("R11 next err", int'(rd_err), 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule